// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped watchdog that counts a timeout down and expects software to refresh it only during a programmable slice of each period. Software unlocks a refresh by writing two bytes to the refresh location in a fixed order. The first completed pair after reset loads the counter and starts it. Every later pair reloads the counter, provided the counter is inside the allowed window at that moment.

The period and the count-clock divider are chosen by fields of a control register. A second register picks how the block responds: an interrupt output or a reset request. Both registers take a single write and then lock until the next reset. An underflow or a refresh fault sets a sticky status flag. That flag drives the selected response output until software clears it. A debug input freezes counting while it is high.

Top module: `wdw_top`

## Requirements
- R1: After reset the counter is idle, the control, status and response registers all read 0, and both outputs are low. Without a refresh pair, no underflow ever occurs.
- R2: Registers sit at byte offsets 0x0 (refresh, bits [7:0]), 0x2 (control, 16 bits), 0x4 (status) and 0x6 (response select, bits [7:0]).
- R3: A write of 0x00 followed by a write of 0xFF to offset 0x0 forms a refresh pair. The first pair after reset loads the counter and starts it. At divide-by-1, the underflow flag sets exactly P clock edges after the edge that took the 0xFF, where P is the period.
- R4: Control bits [1:0] set the period P: 00 gives 1024, 01 gives 4096, 10 gives 8192, 11 gives 16384 count ticks.
- R5: Control bits [7:4] set the count-clock divider: 0000 gives /1, 0001 gives /4, 0101 gives /256, 1000 gives /8192, and any other code gives /1.
- R6: The window is measured on the remaining count C. Bits [13:12] (00, 01, 10, 11) open it once C < P·1/4, 2/4, 3/4 or 4/4. Bits [9:8] (00, 01, 10, 11) close it once C < P·3/4, 2/4, 1/4 or 0, so 11 keeps it open until underflow. A refresh pair completed inside the window reloads the counter to P-1.
- R7: A refresh pair completed while the counter runs but the window is shut sets the refresh-error flag (status bit 1) and leaves the count untouched.
- R8: Any write to offset 0x0 other than 0x00, or 0xFF not directly preceded by an arming 0x00, sets the refresh-error flag. Repeated 0x00 writes keep the pair armed.
- R9: The control and response registers each accept one write. They lock after that write, or once counting starts, until the next reset.
- R10: The underflow flag (status bit 0) and the refresh-error flag (status bit 1) stay set until software writes 0 to that bit. Writing 1 to a bit leaves it unchanged.
- R11: Response-register bit 7 steers the flags. When it is 0, irq_o is high while either flag is set. When it is 1, rst_req_o is high instead. The two outputs are never high together.
- R12: While dbg_halt is high the count and the prescaler stay frozen. Counting resumes from the same value when dbg_halt drops.
- R13: On underflow the counter reloads to P-1 and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| dbg_halt | input | 1 | Freezes counting while high |
| irq_o | output | 1 | Interrupt response level |
| rst_req_o | output | 1 | Reset-request response level |

## Verification
Each period code is started and the underflow edge is located to the exact cycle. The prescaler is checked the same way: /4 against /1, an unused code against /1, and /256 against the undivided period. Refresh pairs are issued early, mid-period and late against a narrow window, and once against a fully open window. Whether the underflow moves tells a reload apart from an ignored refresh. Broken byte sequences, a repeated arming byte, second configuration writes, writes issued after start, and a halt of a known length each produce a distinct, predictable status value or underflow time.

// File: rtl/wdw_pkg.sv
// Shared offsets, byte codes and field decoders for the windowed watchdog.
// Assumes byte-addressed registers on even offsets and a 16-bit control word.
package wdw_pkg;

    localparam int unsigned OFS_REFRESH = 0;
    localparam int unsigned OFS_CTRL    = 2;
    localparam int unsigned OFS_STATUS  = 4;
    localparam int unsigned OFS_RESP    = 6;

    localparam logic [7:0] ARM_BYTE  = 8'h00;
    localparam logic [7:0] FIRE_BYTE = 8'hFF;

    // Control field positions (decoded by the counter and prescaler).
    localparam int unsigned PER_LSB   = 0;
    localparam int unsigned DIV_LSB   = 4;
    localparam int unsigned WEND_LSB  = 8;
    localparam int unsigned WOPEN_LSB = 12;
    localparam int unsigned RESP_SEL_BIT = 7;

    // Extra period exponent above the base period for each period code.
    function automatic int unsigned period_ext(input logic [1:0] code);
        case (code)
            2'b00:   return 0;
            2'b01:   return 2;
            2'b10:   return 3;
            default: return 4;
        endcase
    endfunction

    // Divider exponent for each divider code; unknown codes divide by one.
    function automatic int unsigned div_shift(input logic [3:0] code);
        case (code)
            4'b0001: return 2;
            4'b0101: return 8;
            4'b1000: return 13;
            default: return 0;
        endcase
    endfunction

    // Quarters of the period below which the window opens.
    function automatic int unsigned open_quarters(input logic [1:0] code);
        return int'(code) + 1;
    endfunction

    // Quarters of the period below which the window closes.
    function automatic int unsigned close_quarters(input logic [1:0] code);
        return 3 - int'(code);
    endfunction

endpackage

// File: rtl/wdw_prescaler.sv
// Count-clock prescaler: emits one tick every 2^shift enabled cycles.
// Assumes PRESC_W covers the largest divider exponent; clr restarts the phase.
module wdw_prescaler #(
    parameter int PRESC_W = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       clr,
    input  logic [3:0] div_sel,
    output logic       tick
);
    import wdw_pkg::*;

    localparam int LIM_W = PRESC_W + 1;

    logic [PRESC_W-1:0] phase_q;
    logic [LIM_W-1:0]   limit;

    // Terminal phase value for the selected divider.
    always_comb begin
        limit = (LIM_W'(1) << div_shift(div_sel)) - LIM_W'(1);
        tick  = en && ({1'b0, phase_q} == limit);
    end

    // Phase counter, frozen when disabled, cleared on a counter load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (en) begin
            if (tick) phase_q <= '0;
            else      phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdw_counter.sv
// Down-counter with period decode and refresh-window comparison.
// Assumes load and tick are single-cycle strobes; load wins over tick.
module wdw_counter #(
    parameter int BASE_SHIFT = 10,
    parameter int CNT_W      = BASE_SHIFT + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [1:0]       period_sel,
    input  logic [1:0]       open_sel,
    input  logic [1:0]       close_sel,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             running_o,
    output logic             uf_evt_o,
    output logic             win_open_o
);
    import wdw_pkg::*;

    localparam int LIM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [LIM_W-1:0] period, quarter, open_lim, close_lim, per_m1;

    // Period, reload value and window edges from the control fields.
    always_comb begin
        period    = LIM_W'(1) << (BASE_SHIFT + period_ext(period_sel));
        quarter   = period >> 2;
        per_m1    = period - LIM_W'(1);
        open_lim  = quarter * LIM_W'(open_quarters(open_sel));
        close_lim = quarter * LIM_W'(close_quarters(close_sel));
    end

    // Window status and underflow strobe on the present count.
    always_comb begin
        reload_o   = per_m1[CNT_W-1:0];
        win_open_o = ({1'b0, cnt_q} < open_lim) && ({1'b0, cnt_q} >= close_lim);
        uf_evt_o   = run_q && tick && !load && (cnt_q == '0);
    end

    // Count register: load, decrement per tick, wrap to the reload on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= reload_o;
            run_q <= 1'b1;
        end else if (run_q && tick) begin
            if (cnt_q == '0) cnt_q <= reload_o;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o     = cnt_q;
    assign running_o = run_q;

endmodule

// File: rtl/wdw_regs.sv
// Register file: refresh byte sequencer, write-once configuration,
// sticky status flags and read mux. Assumes at most one write per cycle.
module wdw_regs #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              running,
    input  logic              win_open,
    input  logic              uf_evt,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [7:0]        resp_o,
    output logic              start_evt,
    output logic              reload_evt,
    output logic              err_evt,
    output logic              uf_flag,
    output logic              err_flag,
    output logic [DATA_W-1:0] rdata
);
    import wdw_pkg::*;

    logic              armed_q, ctrl_lock_q, resp_lock_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [7:0]        resp_q;
    logic              uf_q, err_q;
    logic              wr_ref, wr_ctrl, wr_stat, wr_resp;
    logic              is_arm, is_fire, bad_seq;

    // Address decode of the write strobe.
    always_comb begin
        wr_ref  = bus_wr && (bus_addr == ADDR_W'(OFS_REFRESH));
        wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
        wr_resp = bus_wr && (bus_addr == ADDR_W'(OFS_RESP));
    end

    // Refresh pair classification and its outcome.
    always_comb begin
        is_arm     = wr_ref && (bus_wdata[7:0] == ARM_BYTE);
        is_fire    = wr_ref && (bus_wdata[7:0] == FIRE_BYTE) && armed_q;
        bad_seq    = wr_ref && !is_arm && !is_fire;
        start_evt  = is_fire && !running;
        reload_evt = is_fire && running && win_open;
        err_evt    = bad_seq || (is_fire && running && !win_open);
    end

    // Arming state of the two-byte refresh sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed_q <= 1'b0;
        else if (wr_ref) armed_q <= is_arm;
    end

    // Control register, writable once before counting starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            ctrl_lock_q <= 1'b0;
        end else begin
            if (wr_ctrl && !ctrl_lock_q) ctrl_q <= bus_wdata;
            if (wr_ctrl || start_evt)    ctrl_lock_q <= 1'b1;
        end
    end

    // Response register, writable once before counting starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q      <= '0;
            resp_lock_q <= 1'b0;
        end else begin
            if (wr_resp && !resp_lock_q) resp_q <= bus_wdata[7:0];
            if (wr_resp || start_evt)    resp_lock_q <= 1'b1;
        end
    end

    // Sticky flags: an event sets, a written zero clears, the event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (uf_evt)                     uf_q <= 1'b1;
            else if (wr_stat && !bus_wdata[0]) uf_q <= 1'b0;
            if (err_evt)                    err_q <= 1'b1;
            else if (wr_stat && !bus_wdata[1]) err_q <= 1'b0;
        end
    end

    // Read mux; the refresh location reads as zero.
    always_comb begin
        rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL):   rdata = ctrl_q;
            ADDR_W'(OFS_STATUS): rdata = DATA_W'({err_q, uf_q});
            ADDR_W'(OFS_RESP):   rdata = DATA_W'(resp_q);
            default:             rdata = '0;
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign resp_o   = resp_q;
    assign uf_flag  = uf_q;
    assign err_flag = err_q;

endmodule

// File: rtl/wdw_top.sv
// Windowed watchdog top: wires registers, prescaler and counter and steers
// the sticky flags to the interrupt or reset-request output.
// Assumes a single clock and a synchronous active-low reset.
module wdw_top #(
    parameter int BASE_SHIFT = 10,
    parameter int PRESC_W    = 13,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_halt,
    output logic              irq_o,
    output logic              rst_req_o
);
    import wdw_pkg::*;

    localparam int CNT_W = BASE_SHIFT + 4;

    logic [DATA_W-1:0] ctrl_q;
    logic [7:0]        resp_q;
    logic              start_evt, reload_evt, err_evt;
    logic              uf_flag, err_flag;
    logic              running, win_open, uf_evt, tick, load;
    logic [CNT_W-1:0]  cnt, reload_val;

    wdw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .running(running), .win_open(win_open),
        .uf_evt(uf_evt), .ctrl_o(ctrl_q), .resp_o(resp_q),
        .start_evt(start_evt), .reload_evt(reload_evt), .err_evt(err_evt),
        .uf_flag(uf_flag), .err_flag(err_flag), .rdata(bus_rdata)
    );

    // A counter load happens on start or on an accepted refresh.
    assign load = start_evt || reload_evt;

    wdw_prescaler #(.PRESC_W(PRESC_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .en(running && !dbg_halt), .clr(load),
        .div_sel(ctrl_q[DIV_LSB +: 4]), .tick(tick)
    );

    wdw_counter #(.BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(load), .tick(tick),
        .period_sel(ctrl_q[PER_LSB +: 2]), .open_sel(ctrl_q[WOPEN_LSB +: 2]),
        .close_sel(ctrl_q[WEND_LSB +: 2]), .cnt_o(cnt), .reload_o(reload_val),
        .running_o(running), .uf_evt_o(uf_evt), .win_open_o(win_open)
    );

    // Response steering from the sticky flags.
    always_comb begin
        irq_o     = (uf_flag || err_flag) && !resp_q[RESP_SEL_BIT];
        rst_req_o = (uf_flag || err_flag) &&  resp_q[RESP_SEL_BIT];
    end

endmodule

// File: rtl/wdw_chk.sv
// Property checker for the windowed watchdog, bound into wdw_top.
module wdw_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              dbg_halt,
    input logic              irq_o,
    input logic              rst_req_o,
    input logic              running,
    input logic              load,
    input logic              uf_evt,
    input logic              uf_flag,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload_val,
    input logic [DATA_W-1:0] ctrl_q
);
    // R11
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && rst_req_o));

    // R3
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= reload_val));

    // R13
    uf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> (cnt == $past(reload_val)));

    // R12
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && !load) |=> $stable(cnt));

    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(ctrl_q));

    // R10
    uf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uf_flag) |-> $past(bus_wr && (bus_addr == ADDR_W'(4)) && !bus_wdata[0]));

endmodule

bind wdw_top wdw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dbg_halt(dbg_halt), .irq_o(irq_o),
    .rst_req_o(rst_req_o), .running(running), .load(load), .uf_evt(uf_evt),
    .uf_flag(uf_flag), .cnt(cnt), .reload_val(reload_val), .ctrl_q(ctrl_q)
);

// File: tb/wdw_top_tb_top.sv
// Directed bench for wdw_top: one task per scenario, each self-checking.
module wdw_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P1K = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        irq_o, rst_req_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdw_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // All bus tasks start and end just after a falling edge.
    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; dbg_halt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        bus_addr = 3'(addr); bus_wdata = 16'(data); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        bus_addr = 3'(addr);
        #1;
        data = int'(bus_rdata);
    endtask

    task automatic ping();
        wr(0, 'h00);
        wr(0, 'hFF);
    endtask

    task automatic expect_status(input string tag, input int exp);
        int v;
        rd(4, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        rd(2, v); check("R1 R2 control after reset", v, 0);
        rd(4, v); check("R1 R2 status after reset", v, 0);
        rd(6, v); check("R1 R2 response after reset", v, 0);
        check("R1 irq after reset", int'(irq_o), 0);
        check("R1 rst_req after reset", int'(rst_req_o), 0);
        idle(P1K + 100);
        expect_status("R1 no underflow while idle", 0);
    endtask

    task automatic t_period(input int code, input int per, input bit chain);
        do_reset();
        wr(2, code);
        ping();
        idle(per - 1);
        expect_status("R4 no underflow before period", 0);
        idle(1);
        expect_status("R3 R4 underflow at period", 1);
        check("R11 irq in interrupt mode", int'(irq_o), 1);
        check("R11 rst_req quiet in interrupt mode", int'(rst_req_o), 0);
        if (chain) begin
            wr(4, 0);
            expect_status("R10 underflow flag cleared", 0);
            check("R10 irq drops after clear", int'(irq_o), 0);
            idle(per - 2);
            expect_status("R13 no second underflow early", 0);
            idle(1);
            expect_status("R13 second underflow one period later", 1);
        end
    endtask

    task automatic t_divider();
        do_reset();
        wr(2, 'h0010);
        ping();
        idle(4 * P1K - 1);
        expect_status("R5 divide by 4 not yet", 0);
        idle(1);
        expect_status("R5 divide by 4 underflow", 1);
        do_reset();
        wr(2, 'h0020);
        ping();
        idle(P1K - 1);
        expect_status("R5 unused code acts as /1, early", 0);
        idle(1);
        expect_status("R5 unused code acts as /1", 1);
        do_reset();
        wr(2, 'h0050);
        ping();
        idle(P1K + 5);
        expect_status("R5 divide by 256 slower than period", 0);
    endtask

    task automatic t_window_in();
        do_reset();
        wr(2, 'h2200);
        wr(6, 'h80);
        ping();
        idle(400);
        ping();
        expect_status("R6 refresh inside window accepted", 0);
        check("R6 no reset request on good refresh", int'(rst_req_o), 0);
        idle(P1K - 1);
        expect_status("R6 reload pushed underflow out", 0);
        idle(1);
        expect_status("R6 underflow one period after reload", 1);
        check("R11 rst_req in reset mode", int'(rst_req_o), 1);
        check("R11 irq quiet in reset mode", int'(irq_o), 0);
    endtask

    task automatic t_window_out();
        do_reset();
        wr(2, 'h2200);
        wr(6, 'h80);
        ping();
        ping();
        expect_status("R7 early refresh flagged", 2);
        check("R11 rst_req on refresh error", int'(rst_req_o), 1);
        check("R11 irq quiet on refresh error", int'(irq_o), 0);
        idle(P1K - 3);
        expect_status("R7 early refresh did not reload", 2);
        idle(1);
        expect_status("R7 original underflow kept", 3);
        do_reset();
        wr(2, 'h2200);
        ping();
        idle(850);
        ping();
        expect_status("R7 late refresh flagged", 2);
        idle(171);
        expect_status("R7 late refresh did not reload", 2);
        idle(1);
        expect_status("R7 underflow at original time", 3);
    endtask

    task automatic t_window_full();
        do_reset();
        wr(2, 'h3300);
        ping();
        ping();
        expect_status("R6 full window accepts at once", 0);
        idle(1000);
        ping();
        expect_status("R6 full window accepts near underflow", 0);
    endtask

    task automatic t_sequence();
        do_reset();
        ping();
        wr(0, 'h55);
        expect_status("R8 stray byte flagged", 2);
        check("R8 stray byte drives irq", int'(irq_o), 1);
        do_reset();
        wr(2, 'h3300);
        ping();
        wr(0, 'hFF);
        expect_status("R8 unarmed 0xFF flagged", 2);
        do_reset();
        wr(2, 'h3300);
        ping();
        wr(0, 'h00);
        wr(0, 'h00);
        wr(0, 'hFF);
        expect_status("R8 repeated arm then fire accepted", 0);
    endtask

    task automatic t_lock();
        int v;
        do_reset();
        wr(2, 'h0001);
        wr(2, 'h0003);
        rd(2, v); check("R9 second control write ignored", v, 1);
        wr(6, 'h80);
        wr(6, 'h00);
        rd(6, v); check("R9 second response write ignored", v, 'h80);
        do_reset();
        ping();
        wr(2, 'h0003);
        rd(2, v); check("R9 control locked after start", v, 0);
        wr(6, 'h80);
        rd(6, v); check("R9 response locked after start", v, 0);
    endtask

    task automatic t_status();
        do_reset();
        wr(0, 'h55);
        expect_status("R10 error flag set", 2);
        idle(20);
        expect_status("R10 error flag sticky", 2);
        wr(4, 3);
        expect_status("R10 writing ones keeps flags", 2);
        wr(4, 1);
        expect_status("R10 writing zero clears error", 0);
        check("R10 irq low after clear", int'(irq_o), 0);
    endtask

    task automatic t_halt();
        do_reset();
        ping();
        idle(100);
        dbg_halt = 1'b1;
        idle(50);
        dbg_halt = 1'b0;
        idle(P1K - 101);
        expect_status("R12 halt delayed underflow", 0);
        idle(1);
        expect_status("R12 underflow after halted cycles", 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_period('h0000, 1024, 1'b1);
        t_period('h0001, 4096, 1'b0);
        t_period('h0002, 8192, 1'b0);
        t_period('h0003, 16384, 1'b0);
        t_divider();
        t_window_in();
        t_window_out();
        t_window_full();
        t_sequence();
        t_lock();
        t_status();
        t_halt();
        finish_run();
    end

endmodule